// File: doc/BRIEF.md
# SPI Slave Transfer Pause Gate

This block sits between the synchronised pins of an SPI slave port and the slave's shift logic. It samples chip select, serial clock, serial data in and an active-low pause request on the system clock. It turns serial-clock edges into single-cycle strobes for the slave core: a sample strobe with the captured data bit on each rising edge, and a shift strobe on each falling edge. It also produces the enable for the serial data output driver.

A host may pull the pause request low in the middle of a frame. While the block is paused it emits no strobes, so the slave's bit counter and shift registers keep their state. When the host releases the pause, the transfer continues from the bit where it stopped. Entering or leaving the pause is recognised only while the serial clock is low. The output driver, however, is switched off in the same cycle that the pause request is seen low. A deselect always wins: it cancels any pause and tells the core to reset its frame.

The FSM has four states. `HG_IDLE` means deselected. `HG_RUN` means strobes pass through. `HG_ARMED` means a pause was requested while the clock was high and the block is waiting for the falling edge. `HG_PAUSED` means all strobes are blocked. The transitions are:

- select: `HG_IDLE` to `HG_RUN`, or to `HG_ARMED` / `HG_PAUSED` if the pause request is already low at select.
- pause-now: `HG_RUN` to `HG_PAUSED` when the request is low and the clock is low.
- pause-defer: `HG_RUN` to `HG_ARMED` when the request is low and the clock is high.
- pause-take: `HG_ARMED` to `HG_PAUSED` when the clock falls.
- pause-cancel: `HG_ARMED` to `HG_RUN` when the request returns high before that fall.
- resume: `HG_PAUSED` to `HG_RUN` when the request rises while the clock is low.
- deselect: any state to `HG_IDLE` when chip select is high.

Top module: `spi_hold_gate`

## Requirements
- R1: During and after reset, with chip select high, `sample_stb`, `shift_stb`, `sdo_oe`, `paused` and `rx_bit` are 0 and `frame_clr` is 1.
- R2: When selected and not paused, every rising serial-clock edge gives exactly one `sample_stb` pulse and loads `rx_bit` with the data-in level at that edge. Every falling edge gives one `shift_stb` pulse. A pin change seen before clock edge n shows on the outputs after edge n+SYNC_STAGES.
- R3: If the pause request is sampled low while the serial clock is low, `paused` rises in the same cycle. No strobe is emitted for that sample, including a falling edge seen in the same sample.
- R4: If the pause request falls while the serial clock is high, the block waits for the next falling edge. That edge produces no `shift_stb`, and `paused` rises in the same cycle.
- R5: If the pause request returns high before that falling edge, no pause takes place, and the falling edge produces a normal `shift_stb`.
- R6: While paused, serial-clock and data-in transitions produce no strobe, and `rx_bit` holds its value.
- R7: A pause ends only on a rise of the pause request sampled with the serial clock low. A rise seen with the clock high leaves the block paused until the request goes low and rises again with the clock low.
- R8: `sdo_oe` is 0 whenever the sampled pause request is low, whenever chip select is high, and whenever the block is paused. In other cases it is 1.
- R9: Chip select high forces the idle state, clears `paused` and holds `frame_clr` at 1. A select made while the pause request is low enters the pause, or arms it if the clock is high.
- R10: On resume, `sdo_oe` returns in the same cycle that `paused` falls, and no strobe is produced until the next serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_clk | input | 1 | Serial clock pin |
| spi_mosi | input | 1 | Serial data in pin |
| pause_req_n | input | 1 | Pause request, active low |
| sample_stb | output | 1 | One-cycle strobe on each accepted rising serial-clock edge |
| shift_stb | output | 1 | One-cycle strobe on each accepted falling serial-clock edge |
| rx_bit | output | 1 | Data-in bit captured at the last sample strobe |
| sdo_oe | output | 1 | Drive enable for the serial data out pin |
| frame_clr | output | 1 | High while deselected; the core resets its frame |
| paused | output | 1 | High while the transfer is suspended |

## Verification
The assertions assume that pins change only between system clock edges and that each level lasts long enough for the synchronisers to capture it. They also assume that chip select does not change in the same sample as a serial-clock edge. The stimulus keeps every pin level for several system clocks and moves chip select only while the serial clock is low. It covers a pause requested with the clock low, a pause requested with the clock high, a cancelled arming, a release attempted with the clock high, a deselect during a pause, and a select made with the pause already requested.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [1:0] {
        HG_IDLE   = 2'd0,
        HG_RUN    = 2'd1,
        HG_ARMED  = 2'd2,
        HG_PAUSED = 2'd3
    } hg_state_e;

    typedef struct packed {
        logic csn;
        logic hold_n;
        logic sck;
        logic sdi;
    } pin_t;

    localparam pin_t PIN_IDLE = '{csn: 1'b1, hold_n: 1'b1, sck: 1'b0, sdi: 1'b0};

endpackage

// File: rtl/hg_pin_capture.sv
module hg_pin_capture
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  pin_t pins,
    output pin_t cur,
    output pin_t prev
);

    pin_t stage [SYNC_STAGES];
    pin_t prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage[0] <= PIN_IDLE;
        end else begin
            stage[0] <= pins;
        end
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[i] <= PIN_IDLE;
                end else begin
                    stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= PIN_IDLE;
        end else begin
            prev_q <= stage[SYNC_STAGES-1];
        end
    end

    assign cur  = stage[SYNC_STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/hg_pause_fsm.sv
module hg_pause_fsm
    import spi_hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_t      cur,
    input  pin_t      prev,
    output hg_state_e state_q,
    output hg_state_e state_d,
    output logic      pass
);

    logic clk_fell;
    logic hold_rose;

    assign clk_fell  = prev.sck & ~cur.sck;
    assign hold_rose = cur.hold_n & ~prev.hold_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cur.csn) begin
            state_d = HG_IDLE;
        end else begin
            unique case (state_q)
                HG_IDLE, HG_RUN: begin
                    if (!cur.hold_n) begin
                        state_d = cur.sck ? HG_ARMED : HG_PAUSED;
                    end else begin
                        state_d = HG_RUN;
                    end
                end
                HG_ARMED: begin
                    if (cur.hold_n) begin
                        state_d = HG_RUN;
                    end else if (clk_fell || !cur.sck) begin
                        state_d = HG_PAUSED;
                    end
                end
                HG_PAUSED: begin
                    if (hold_rose && !cur.sck) begin
                        state_d = HG_RUN;
                    end
                end
                default: state_d = HG_IDLE;
            endcase
        end
    end

    assign pass = ((state_q == HG_RUN) || (state_q == HG_ARMED)) &&
                  (state_d != HG_PAUSED) && (state_d != HG_IDLE);

    // R7
    no_resume_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HG_PAUSED && !cur.csn && cur.sck) |=> (state_q == HG_PAUSED));

    // R9
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur.csn |=> (state_q == HG_IDLE));

    // R3
    pause_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HG_RUN && !cur.csn && !cur.hold_n && !cur.sck) |=> (state_q == HG_PAUSED));

endmodule

// File: rtl/hg_strobe_out.sv
module hg_strobe_out
    import spi_hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_t      cur,
    input  pin_t      prev,
    input  hg_state_e state_d,
    input  logic      pass,
    output logic      sample_stb,
    output logic      shift_stb,
    output logic      rx_bit,
    output logic      sdo_oe,
    output logic      frame_clr,
    output logic      paused
);

    logic rose_ev;
    logic fell_ev;

    assign rose_ev = cur.sck & ~prev.sck;
    assign fell_ev = prev.sck & ~cur.sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
            rx_bit     <= 1'b0;
            sdo_oe     <= 1'b0;
            frame_clr  <= 1'b1;
            paused     <= 1'b0;
        end else begin
            sample_stb <= pass & rose_ev;
            shift_stb  <= pass & fell_ev;
            if (pass && rose_ev) begin
                rx_bit <= cur.sdi;
            end
            sdo_oe    <= !cur.csn && cur.hold_n && (state_d == HG_RUN);
            frame_clr <= cur.csn;
            paused    <= (state_d == HG_PAUSED);
        end
    end

    // R8
    oe_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur.hold_n || cur.csn) |=> !sdo_oe);

    // R6
    rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && state_d == HG_PAUSED) |=> ($stable(rx_bit) && !sample_stb && !shift_stb));

    // R2
    stb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));

    // R8
    oe_not_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !sdo_oe);

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_clk,
    input  logic spi_mosi,
    input  logic pause_req_n,
    output logic sample_stb,
    output logic shift_stb,
    output logic rx_bit,
    output logic sdo_oe,
    output logic frame_clr,
    output logic paused
);

    pin_t      pins;
    pin_t      cur;
    pin_t      prev;
    hg_state_e state_q;
    hg_state_e state_d;
    logic      pass;

    assign pins = '{csn: spi_csn, hold_n: pause_req_n, sck: spi_clk, sdi: spi_mosi};

    hg_pin_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (pins),
        .cur  (cur),
        .prev (prev)
    );

    hg_pause_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (cur),
        .prev   (prev),
        .state_q(state_q),
        .state_d(state_d),
        .pass   (pass)
    );

    hg_strobe_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (cur),
        .prev      (prev),
        .state_d   (state_d),
        .pass      (pass),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb),
        .rx_bit    (rx_bit),
        .sdo_oe    (sdo_oe),
        .frame_clr (frame_clr),
        .paused    (paused)
    );

    // R10
    resume_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && state_q == HG_PAUSED && !cur.csn && cur.hold_n && !prev.hold_n && !cur.sck)
        |=> (sdo_oe && !paused && !sample_stb && !shift_stb));

endmodule

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;

    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
    logic sample_stb, shift_stb, rx_bit, sdo_oe, frame_clr, paused;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_hold_gate #(.SYNC_STAGES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_clk(sck), .spi_mosi(sdi),
        .pause_req_n(hold_n), .sample_stb(sample_stb), .shift_stb(shift_stb),
        .rx_bit(rx_bit), .sdo_oe(sdo_oe), .frame_clr(frame_clr), .paused(paused)
    );

    // behavioural reference: 0 idle, 1 running, 2 waiting for fall, 3 paused
    logic [3:0] hist [$];
    int   mode = 0;
    logic e_smp = 0, e_sh = 0, e_rx = 0, e_oe = 0, e_clr = 1, e_pa = 0;

    initial for (int i = 0; i < S + 2; i++) hist.push_front(4'b1100);

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; e_smp = 0; e_sh = 0; e_rx = 0; e_oe = 0; e_clr = 1; e_pa = 0;
            hist.delete();
            for (int i = 0; i < S + 2; i++) hist.push_front(4'b1100);
        end else begin
            logic [3:0] c, p;
            int nm;
            bit up, dn, go;
            hist.push_front({csn, hold_n, sck, sdi});
            void'(hist.pop_back());
            c = hist[S];
            p = hist[S+1];
            up = c[1] && !p[1];
            dn = !c[1] && p[1];
            nm = mode;
            if (c[3]) nm = 0;
            else if (mode == 0 || mode == 1) nm = !c[2] ? (c[1] ? 2 : 3) : 1;
            else if (mode == 2) nm = c[2] ? 1 : ((dn || !c[1]) ? 3 : 2);
            else if (c[2] && !p[2] && !c[1]) nm = 1;
            go = (mode == 1 || mode == 2) && nm != 3 && nm != 0;
            e_smp = go && up;
            e_sh  = go && dn;
            if (go && up) e_rx = c[0];
            e_oe  = !c[3] && c[2] && nm == 1;
            e_clr = c[3];
            e_pa  = (nm == 3);
            mode  = nm;
        end
    end

    task automatic chk(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "sample_stb", sample_stb, e_smp);
            chk("R2", "shift_stb", shift_stb, e_sh);
            chk("R6", "rx_bit", rx_bit, e_rx);
            chk("R8", "sdo_oe", sdo_oe, e_oe);
            chk("R9", "frame_clr", frame_clr, e_clr);
            chk("R3", "paused", paused, e_pa);
        end
    end

    task automatic hold_for(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(logic d);
        sdi = d; hold_for(4);
        sck = 1'b1; hold_for(4);
        sck = 1'b0; hold_for(4);
    endtask

    initial begin
        hold_for(3);
        // R1 reset values
        chk("R1", "sample_stb", sample_stb, 1'b0);
        chk("R1", "sdo_oe", sdo_oe, 1'b0);
        chk("R1", "frame_clr", frame_clr, 1'b1);
        chk("R1", "paused", paused, 1'b0);
        rst_n = 1'b1;
        hold_for(6);
        chk("R1", "rx_bit", rx_bit, 1'b0);

        // R2 plain frame
        csn = 1'b0; hold_for(6);
        chk("R8", "sdo_oe selected", sdo_oe, 1'b1);
        for (int i = 0; i < 8; i++) bit_cycle(i[0] ^ i[2]);

        // R3 pause with clock low, toggle pins during pause (R6)
        hold_n = 1'b0; hold_for(6);
        chk("R3", "paused low", paused, 1'b1);
        chk("R8", "oe in pause", sdo_oe, 1'b0);
        for (int i = 0; i < 3; i++) bit_cycle(~i[0]);
        hold_n = 1'b1; hold_for(6);
        chk("R10", "resumed", paused, 1'b0);
        chk("R10", "oe back", sdo_oe, 1'b1);
        bit_cycle(1'b1); bit_cycle(1'b0);

        // R4 pause requested with clock high
        sdi = 1'b1; hold_for(4); sck = 1'b1; hold_for(4);
        hold_n = 1'b0; hold_for(6);
        chk("R4", "not yet paused", paused, 1'b0);
        chk("R8", "oe off armed", sdo_oe, 1'b0);
        sck = 1'b0; hold_for(6);
        chk("R4", "paused at fall", paused, 1'b1);
        bit_cycle(1'b0);
        hold_n = 1'b1; hold_for(6);
        bit_cycle(1'b0);

        // R5 arming cancelled
        sck = 1'b1; hold_for(4);
        hold_n = 1'b0; hold_for(5);
        hold_n = 1'b1; hold_for(5);
        sck = 1'b0; hold_for(6);
        chk("R5", "no pause", paused, 1'b0);

        // R7 release attempted with clock high
        hold_n = 1'b0; hold_for(5);
        sck = 1'b1; hold_for(4);
        hold_n = 1'b1; hold_for(6);
        chk("R7", "still paused", paused, 1'b1);
        sck = 1'b0; hold_for(6);
        chk("R7", "still paused low", paused, 1'b1);
        hold_n = 1'b0; hold_for(4);
        hold_n = 1'b1; hold_for(6);
        chk("R7", "resumed", paused, 1'b0);
        bit_cycle(1'b1);

        // R9 deselect during pause
        hold_n = 1'b0; hold_for(5);
        csn = 1'b1; hold_for(6);
        chk("R9", "pause cleared", paused, 1'b0);
        chk("R9", "frame_clr", frame_clr, 1'b1);
        bit_cycle(1'b1);
        // R9 select while pause already requested
        csn = 1'b0; hold_for(6);
        chk("R9", "select into pause", paused, 1'b1);
        hold_n = 1'b1; hold_for(6);
        bit_cycle(1'b0); bit_cycle(1'b1);
        csn = 1'b1; hold_for(8);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule